// File: doc/BRIEF.md
# In-Order Completion Issue Controller

This block keeps results of a multi-latency execution core in program order. It keeps a table with one row for each cycle of the longest execution pipeline. Row 1 is the row that completes in the current cycle. An instruction that needs `i` cycles claims row `i` when it is accepted. On every clock the whole table moves one row towards row 1, and an empty row enters at the far end. The row sitting in row 1 drives the register-file write for that cycle: the write enable, the destination register, the functional-unit select and the program counter.

When an instruction claims row `i`, every empty row between row 1 and row `i-1` is filled with a placeholder. A placeholder is occupied but carries no data. Because of this, no instruction accepted later can claim a row that completes earlier. Register writes therefore leave the block in the same order as instructions were accepted. A placeholder that reaches row 1 produces no write.

Requests arrive on a valid/ready stream. `iss_ready` is combinational. It depends on `iss_lat` and on the table, and never on `iss_valid`. A transfer takes place in a cycle where both valid and ready are high. While ready is low, the requester keeps valid high and holds the payload unchanged. The block records nothing from a cycle without a transfer.

Top module: `rsr_issue_ctrl`

## Requirements
- R1: Reset empties every row. After reset `wb_en` is 0, and `iss_ready` is 1 for every legal latency.
- R2: A legal latency lies in the range 1 to ROWS (8 by default). For a latency of 0 or above ROWS, `iss_ready` stays 0 and nothing is recorded.
- R3: The readiness check uses the table as it will be after this cycle's move. A request of latency `i` is ready exactly when the row now at position `i+1` is empty, with latency ROWS always free. So a row that is occupied now but moves up this cycle does not block a request.
- R4: An instruction accepted in cycle `c` with latency `i` appears at the write port in cycle `c+i`. In that cycle `wb_en` is 1 and `wb_fu`, `wb_dst` and `wb_pc` equal the values that were accepted.
- R5: On acceptance with latency `i`, every empty row from 1 to `i-1` becomes a placeholder. Rows already holding an instruction keep it. A later request whose row would complete earlier is refused.
- R6: A placeholder or an empty row in row 1 drives `wb_en` = 0.
- R7: On each clock every row moves up one position. Row ROWS is refilled with an empty entry, unless that same cycle's transfer claims it.
- R8: For any mix of latencies, register writes occur in the order the instructions were accepted, and each appears exactly its latency after acceptance.
- R9: A request refused by back-pressure leaves no trace. Only transferred instructions ever appear at the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request present |
| iss_ready | output | 1 | Request may transfer this cycle |
| iss_lat | input | LAT_W | Execution latency in cycles |
| iss_fu | input | FU_W | Functional unit producing the result |
| iss_dst | input | DST_W | Destination register |
| iss_pc | input | PC_W | Program counter of the instruction |
| wb_en | output | 1 | Register write in this cycle |
| wb_fu | output | FU_W | Functional unit to select for the write |
| wb_dst | output | DST_W | Register to write |
| wb_pc | output | PC_W | Program counter of the completing instruction |

## Verification
The check for a new request and the upward move of the table happen in the same cycle. This matters most when a request names the row that an earlier instruction occupies at that moment. The bench provokes this case in two ways. First, it requests latency `i-1` right after an instruction of latency `i`, which must be refused. Second, it requests a latency equal to the earlier instruction's current row, which must be granted because that instruction moves out of the row. Each case is judged by the grant seen at the port, and by the exact cycles and order of the two resulting writes.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  typedef enum logic [1:0] {
    RK_EMPTY = 2'd0,
    RK_NULL  = 2'd1,
    RK_LIVE  = 2'd2
  } row_kind_e;
endpackage

// File: rtl/rsr_table.sv
module rsr_table #(
  parameter int ROWS  = 8,
  parameter int FU_W  = 3,
  parameter int DST_W = 5,
  parameter int PC_W  = 16,
  parameter int LAT_W = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             fire,
  input  logic [LAT_W-1:0]                 lat,
  input  logic [FU_W-1:0]                  fu,
  input  logic [DST_W-1:0]                 dst,
  input  logic [PC_W-1:0]                  pc,
  output rsr_pkg::row_kind_e [ROWS-1:0]    kind_sh,
  output rsr_pkg::row_kind_e               head_kind,
  output logic [FU_W-1:0]                  head_fu,
  output logic [DST_W-1:0]                 head_dst,
  output logic [PC_W-1:0]                  head_pc
);
  import rsr_pkg::*;

  row_kind_e [ROWS-1:0] kind_q;
  logic [FU_W-1:0]      fu_q  [ROWS];
  logic [DST_W-1:0]     dst_q [ROWS];
  logic [PC_W-1:0]      pc_q  [ROWS];

  for (genvar j = 0; j < ROWS; j++) begin : g_row
    row_kind_e        kind_r, up_kind;
    logic [FU_W-1:0]  fu_r, up_fu;
    logic [DST_W-1:0] dst_r, up_dst;
    logic [PC_W-1:0]  pc_r, up_pc;
    logic             hit, below;

    if (j == ROWS - 1) begin : g_top
      assign up_kind = RK_EMPTY;
      assign up_fu   = '0;
      assign up_dst  = '0;
      assign up_pc   = '0;
    end else begin : g_mid
      assign up_kind = kind_q[j+1];
      assign up_fu   = fu_q[j+1];
      assign up_dst  = dst_q[j+1];
      assign up_pc   = pc_q[j+1];
    end

    assign hit   = fire && (lat == LAT_W'(j + 1));
    assign below = fire && (lat >  LAT_W'(j + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        kind_r <= RK_EMPTY;
        fu_r   <= '0;
        dst_r  <= '0;
        pc_r   <= '0;
      end else if (hit) begin
        kind_r <= RK_LIVE;
        fu_r   <= fu;
        dst_r  <= dst;
        pc_r   <= pc;
      end else if (below && up_kind == RK_EMPTY) begin
        kind_r <= RK_NULL;
        fu_r   <= '0;
        dst_r  <= '0;
        pc_r   <= '0;
      end else begin
        kind_r <= up_kind;
        fu_r   <= up_fu;
        dst_r  <= up_dst;
        pc_r   <= up_pc;
      end
    end

    assign kind_q[j]  = kind_r;
    assign fu_q[j]    = fu_r;
    assign dst_q[j]   = dst_r;
    assign pc_q[j]    = pc_r;
    assign kind_sh[j] = up_kind;

    // R5: rows below a fresh reservation are occupied afterwards
    a_r5_fill_below: assert property (@(posedge clk) disable iff (!rst_n)
      fire && (lat > LAT_W'(j + 1)) |=> kind_q[j] != RK_EMPTY);

    if (j < ROWS - 1) begin : g_shift_chk
      // R7: with no transfer every row takes its upper neighbour
      a_r7_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> kind_q[j] == $past(kind_q[j+1]));
    end
  end

  assign head_kind = kind_q[0];
  assign head_fu   = fu_q[0];
  assign head_dst  = dst_q[0];
  assign head_pc   = pc_q[0];

  // R4: the claimed row holds the accepted instruction
  a_r4_reserve: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> kind_q[$past(lat) - 1'b1] == RK_LIVE &&
             pc_q[$past(lat) - 1'b1] == $past(pc));

  // R3: a grant never lands on a row that is still occupied after the move
  a_r3_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> kind_sh[lat - 1'b1] == RK_EMPTY);

  // R7: the far row is refilled empty unless claimed
  a_r7_top_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && lat == LAT_W'(ROWS)) |=> kind_q[ROWS-1] == RK_EMPTY);
endmodule

// File: rtl/rsr_grant.sv
module rsr_grant #(
  parameter int ROWS  = 8,
  parameter int LAT_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LAT_W-1:0]              lat,
  input  rsr_pkg::row_kind_e [ROWS-1:0] kind_sh,
  output logic                          ready
);
  import rsr_pkg::*;

  always_comb begin
    ready = 1'b0;
    for (int j = 0; j < ROWS; j++) begin
      if (lat == LAT_W'(j + 1)) ready = (kind_sh[j] == RK_EMPTY);
    end
  end

  // R2: readiness only for legal latencies
  a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (lat != '0) && (lat <= LAT_W'(ROWS)));
endmodule

// File: rtl/rsr_retire.sv
module rsr_retire #(
  parameter int FU_W  = 3,
  parameter int DST_W = 5,
  parameter int PC_W  = 16
) (
  input  rsr_pkg::row_kind_e head_kind,
  input  logic [FU_W-1:0]    head_fu,
  input  logic [DST_W-1:0]   head_dst,
  input  logic [PC_W-1:0]    head_pc,
  output logic               wb_en,
  output logic [FU_W-1:0]    wb_fu,
  output logic [DST_W-1:0]   wb_dst,
  output logic [PC_W-1:0]    wb_pc
);
  import rsr_pkg::*;

  always_comb begin
    wb_en  = (head_kind == RK_LIVE);
    wb_fu  = wb_en ? head_fu  : '0;
    wb_dst = wb_en ? head_dst : '0;
    wb_pc  = wb_en ? head_pc  : '0;
  end
endmodule

// File: rtl/rsr_issue_ctrl.sv
module rsr_issue_ctrl #(
  parameter int ROWS  = 8,
  parameter int FU_W  = 3,
  parameter int DST_W = 5,
  parameter int PC_W  = 16,
  parameter int LAT_W = $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [LAT_W-1:0] iss_lat,
  input  logic [FU_W-1:0]  iss_fu,
  input  logic [DST_W-1:0] iss_dst,
  input  logic [PC_W-1:0]  iss_pc,
  output logic             wb_en,
  output logic [FU_W-1:0]  wb_fu,
  output logic [DST_W-1:0] wb_dst,
  output logic [PC_W-1:0]  wb_pc
);
  import rsr_pkg::*;

  row_kind_e [ROWS-1:0] kind_sh;
  row_kind_e            head_kind;
  logic [FU_W-1:0]      head_fu;
  logic [DST_W-1:0]     head_dst;
  logic [PC_W-1:0]      head_pc;
  logic                 fire;

  assign fire = iss_valid && iss_ready;

  rsr_grant #(.ROWS(ROWS), .LAT_W(LAT_W)) u_grant (
    .clk(clk), .rst_n(rst_n), .lat(iss_lat), .kind_sh(kind_sh), .ready(iss_ready)
  );

  rsr_table #(.ROWS(ROWS), .FU_W(FU_W), .DST_W(DST_W), .PC_W(PC_W), .LAT_W(LAT_W)) u_table (
    .clk(clk), .rst_n(rst_n), .fire(fire), .lat(iss_lat), .fu(iss_fu),
    .dst(iss_dst), .pc(iss_pc), .kind_sh(kind_sh), .head_kind(head_kind),
    .head_fu(head_fu), .head_dst(head_dst), .head_pc(head_pc)
  );

  rsr_retire #(.FU_W(FU_W), .DST_W(DST_W), .PC_W(PC_W)) u_retire (
    .head_kind(head_kind), .head_fu(head_fu), .head_dst(head_dst), .head_pc(head_pc),
    .wb_en(wb_en), .wb_fu(wb_fu), .wb_dst(wb_dst), .wb_pc(wb_pc)
  );
endmodule

// File: tb/rsr_issue_ctrl_bench.sv
module rsr_issue_ctrl_bench;
  localparam int ROWS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [3:0]  iss_lat = '0;
  logic [2:0]  iss_fu = '0;
  logic [4:0]  iss_dst = '0;
  logic [15:0] iss_pc = '0;
  logic        wb_en;
  logic [2:0]  wb_fu;
  logic [4:0]  wb_dst;
  logic [15:0] wb_pc;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  int          wn = 0;
  int          wcyc [512];
  logic [15:0] wpc  [512];
  logic [4:0]  wdst [512];
  logic [2:0]  wfu  [512];

  always #4 clk = ~clk;

  rsr_issue_ctrl u_rsr_issue_ctrl (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_lat(iss_lat), .iss_fu(iss_fu), .iss_dst(iss_dst), .iss_pc(iss_pc),
    .wb_en(wb_en), .wb_fu(wb_fu), .wb_dst(wb_dst), .wb_pc(wb_pc)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && wb_en && wn < 512) begin
      wcyc[wn] = cyc;
      wpc[wn]  = wb_pc;
      wdst[wn] = wb_dst;
      wfu[wn]  = wb_fu;
      wn = wn + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic issue(input logic [3:0] lat, input logic [2:0] fu, input logic [4:0] dst,
                       input logic [15:0] pc, input int tries,
                       output bit got, output int icyc);
    iss_valid = 1'b1; iss_lat = lat; iss_fu = fu; iss_dst = dst; iss_pc = pc;
    got = 1'b0; icyc = -1;
    for (int t = 0; t < tries && !got; t++) begin
      @(negedge clk);
      if (iss_ready) begin got = 1'b1; icyc = cyc; end
      @(posedge clk); #1;
    end
    iss_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(wb_en == 1'b0, "R1", "wb_en after reset", int'(wb_en), 0);
    iss_lat = 4'd1; #1;
    chk(iss_ready == 1'b1, "R1", "ready lat 1 after reset", int'(iss_ready), 1);
    iss_lat = 4'd8; #1;
    chk(iss_ready == 1'b1, "R1", "ready lat 8 after reset", int'(iss_ready), 1);
    @(posedge clk); #1;
  endtask

  task automatic t_range;
    int w0; bit got; int ic;
    w0 = wn;
    issue(4'd0, 3'd1, 5'd1, 16'hA000, 1, got, ic);
    chk(!got, "R2", "latency 0 granted", int'(got), 0);
    issue(4'd9, 3'd1, 5'd1, 16'hA001, 1, got, ic);
    chk(!got, "R2", "latency 9 granted", int'(got), 0);
    idle(12);
    chk(wn == w0, "R2", "writes after illegal latency", wn - w0, 0);
  endtask

  task automatic t_single;
    int w0; bit got; int ic;
    w0 = wn;
    issue(4'd3, 3'd5, 5'd17, 16'h1234, 1, got, ic);
    chk(got, "R4", "lat 3 grant on empty table", int'(got), 1);
    idle(10);
    chk(wn - w0 == 1, "R6", "write count, placeholders silent", wn - w0, 1);
    chk(wcyc[w0] == ic + 3, "R4", "write cycle", wcyc[w0], ic + 3);
    chk(wpc[w0] == 16'h1234, "R4", "write pc", int'(wpc[w0]), 32'h1234);
    chk(wdst[w0] == 5'd17 && wfu[w0] == 3'd5, "R4", "write dst/fu",
        int'({wfu[w0], wdst[w0]}), int'({3'd5, 5'd17}));
  endtask

  task automatic t_same_cycle;
    int w0; bit got; int ia, ib, ix;
    w0 = wn;
    issue(4'd4, 3'd1, 5'd2, 16'hB000, 1, got, ia);
    chk(got, "R3", "first lat 4 grant", int'(got), 1);
    issue(4'd3, 3'd2, 5'd3, 16'hB001, 1, got, ix);
    chk(!got, "R3", "lat 3 behind lat 4 refused", int'(got), 0);
    issue(4'd3, 3'd3, 5'd4, 16'hB002, 1, got, ib);
    chk(got, "R3", "lat 3 into row that moves up granted", int'(got), 1);
    idle(10);
    chk(wn - w0 == 2, "R9", "only granted requests write", wn - w0, 2);
    chk(wpc[w0] == 16'hB000 && wcyc[w0] == ia + 4, "R8", "first write cycle",
        wcyc[w0], ia + 4);
    chk(wpc[w0+1] == 16'hB002 && wcyc[w0+1] == ib + 3, "R8", "second write cycle",
        wcyc[w0+1], ib + 3);
  endtask

  task automatic t_fill;
    int w0; bit got; int ia, ib, ix;
    w0 = wn;
    issue(4'd6, 3'd4, 5'd9, 16'hC000, 1, got, ia);
    chk(got, "R5", "lat 6 grant", int'(got), 1);
    issue(4'd1, 3'd0, 5'd0, 16'hC001, 1, got, ix);
    chk(!got, "R5", "lat 1 refused by placeholder", int'(got), 0);
    issue(4'd2, 3'd0, 5'd0, 16'hC002, 1, got, ix);
    chk(!got, "R5", "lat 2 refused by placeholder", int'(got), 0);
    issue(4'd4, 3'd6, 5'd10, 16'hC003, 1, got, ib);
    chk(got, "R5", "lat 4 granted past earlier row", int'(got), 1);
    idle(10);
    chk(wn - w0 == 2, "R6", "placeholders cause no write", wn - w0, 2);
    chk(wpc[w0] == 16'hC000 && wcyc[w0] == ia + 6, "R5", "long write first",
        int'(wpc[w0]), 32'hC000);
    chk(wpc[w0+1] == 16'hC003 && wcyc[w0+1] == ib + 4, "R7", "second write cycle",
        wcyc[w0+1], ib + 4);
  endtask

  task automatic t_random;
    int w0; bit got; int ic; int n;
    logic [15:0] lfsr;
    int          ecyc [40];
    logic [15:0] epc  [40];
    logic [4:0]  edst [40];
    w0 = wn; n = 0; lfsr = 16'hACE1;
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issue(4'(lfsr[2:0]) + 4'd1, lfsr[5:3], lfsr[10:6], 16'h2000 + 16'(k), 20, got, ic);
      if (got) begin
        ecyc[n] = ic + int'(lfsr[2:0]) + 1;
        epc[n]  = 16'h2000 + 16'(k);
        edst[n] = lfsr[10:6];
        n++;
      end
    end
    chk(n == 40, "R8", "random requests all granted", n, 40);
    idle(12);
    chk(wn - w0 == n, "R8", "random write count", wn - w0, n);
    for (int k = 0; k < n; k++) begin
      chk(wpc[w0+k] == epc[k], "R8", "write order pc", int'(wpc[w0+k]), int'(epc[k]));
      chk(wcyc[w0+k] == ecyc[k], "R8", "write cycle", wcyc[w0+k], ecyc[k]);
      chk(wdst[w0+k] == edst[k], "R4", "write dst", int'(wdst[w0+k]), int'(edst[k]));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_range();
    t_single();
    t_same_cycle();
    t_fill();
    t_random();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule